// File: doc/BRIEF.md
# Three-Pin Serial Audio Receiver with DAC Routing

This block takes stereo audio from a serial port in I2S format. One bit clock and one word clock are shared by three serial data pins. Each pin is deserialised into a 24-bit left sample and a 24-bit right sample. The block counts the bit clocks in every full word-clock period. When a period is exactly 32 bit clocks long, it switches to 16-bit words from the next frame on. At all other times it accepts words of up to 24 bits and left-justifies them.

A one-byte control register holds a 2-bit source field for each of three DAC output channels. Any pin can therefore drive any DAC, and one code blanks a channel. Each DAC channel presents a parallel left/right pair together with a one-cycle strobe. All serial inputs are sampled on a faster system clock and are expected to be synchronous to it. Edges of the bit clock are found by comparing it with its registered copy.

Top module: `i2srx_router`

## Requirements
- R1: After reset the DAC sources are pin 1 for DAC 1 (code 00), pin 2 for DAC 2 (code 01) and pin 3 for DAC 3 (code 10). Reading address 0 then returns 0x24: DAC 1 in bits 1:0, DAC 2 in bits 3:2, DAC 3 in bits 5:4.
- R2: A write with `reg_we` high at address 0 loads bits 5:0 into the source fields, and bits 7:6 read back as zero. A write to any other address leaves the fields unchanged, and reading any other address returns zero.
- R3: Data is sampled on rising bit-clock edges. Word clock low carries the left channel and high carries the right channel. The MSB arrives on the second rising edge after a word-clock change, and the remaining bits follow MSB first.
- R4: In 24-bit mode, with each word-clock phase at least 24 bit clocks long, a word of 16 to 24 bits appears left-justified in the 24-bit output with its unused LSBs at zero.
- R5: When the full word-clock period before a frame was exactly 32 rising bit-clock edges, only the first 16 bits of each word are kept, and output bits 7:0 are zero.
- R6: The word-length decision is taken at each left-channel start, from the period that just ended. The first longer frame after a 32-clock frame is still decoded as 16-bit, and the frame after it as 24-bit.
- R7: `dac_valid` pulses for one clock per frame, when the rising edge that starts the next left channel delivers the last right-channel bit. The pulse presents left and right together. No pulse is given for a frame that began before the first left-channel start seen after reset.
- R8: Each DAC output carries the pair deserialised from the pin that its own 2-bit field selects, independently of the other DACs.
- R9: Code 11 in a field drives zero left and right samples on that DAC, and its strobe still pulses.
- R10: A full period of any length other than 32, such as 48 to 68 clocks, keeps 24-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock, sampled on clk |
| lrclk | input | 1 | Word clock: low = left, high = right |
| din | input | N_PIN | Serial data, one bit per pin |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| dac_left | output | N_PIN*24 | Left samples, DAC k in bits k*24 upward |
| dac_right | output | N_PIN*24 | Right samples, DAC k in bits k*24 upward |
| dac_valid | output | N_PIN | One-cycle strobe per DAC |

## Verification
The last right-channel bit, the frame-done strobe and the word-length update all fall on the same rising bit-clock edge: the one that opens the next left channel. The bench provokes this in sequences that move from 64-clock frames to 32-clock frames and back. It judges the collision by checking two things. The right LSB written on that edge still obeys the old frame's word length. The frame that follows is the first one decoded under the new length. Random word widths and phase lengths, routings and a blanked channel are checked against a bench model of the serial stream.

// File: rtl/i2srx_pkg.sv
`timescale 1ns/1ps
package i2srx_pkg;
    localparam int SAMPLE_W     = 24;
    localparam int SHORT_W      = 16;
    localparam int SHORT_PERIOD = 32;
    localparam int CNT_W        = 8;
    localparam int SEL_W        = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    // Per-edge timing info shared by all deserialisers
    typedef struct packed {
        logic             rise;       // bit-clock rising edge this cycle
        logic             changed;    // word clock differs from last edge
        logic             lr_now;     // word clock at this edge
        logic             lr_prev;    // word clock at previous edge
        logic [CNT_W-1:0] idx;        // bit index within the current word
        logic             short_mode; // 16-bit words in force
        logic             emit;       // frame complete, deliver pair
    } slot_t;

    function automatic sample_t put_bit(sample_t s, logic [CNT_W-1:0] idx,
                                        logic b, logic short_m);
        sample_t r;
        int      lim;
        r   = s;
        lim = short_m ? SHORT_W : SAMPLE_W;
        if (int'(idx) < lim)
            r[SAMPLE_W-1-int'(idx)] = b;
        return r;
    endfunction
endpackage

// File: rtl/i2srx_frame_timer.sv
`timescale 1ns/1ps
module i2srx_frame_timer
    import i2srx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bclk,
    input  logic  lrclk,
    output slot_t slot
);
    logic             bclk_q;
    logic             lr_q;
    logic             framed;
    logic             short_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             rise;
    logic             changed;
    logic             boundary;

    assign rise     = bclk && !bclk_q;
    assign changed  = rise && (lrclk != lr_q);
    assign boundary = changed && !lrclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            lr_q    <= 1'b0;
            framed  <= 1'b0;
            short_q <= 1'b0;
            bit_cnt <= '0;
            per_cnt <= '0;
        end else begin
            bclk_q <= bclk;
            if (rise) begin
                lr_q    <= lrclk;
                bit_cnt <= changed ? '0 : ((bit_cnt == '1) ? bit_cnt : bit_cnt + 1'b1);
                per_cnt <= boundary ? CNT_W'(1) : ((per_cnt == '1) ? per_cnt : per_cnt + 1'b1);
                if (boundary) begin
                    framed <= 1'b1;
                    if (framed)
                        short_q <= (per_cnt == CNT_W'(SHORT_PERIOD));
                end
            end
        end
    end

    always_comb begin
        slot.rise       = rise;
        slot.changed    = changed;
        slot.lr_now     = lrclk;
        slot.lr_prev    = lr_q;
        slot.idx        = bit_cnt;
        slot.short_mode = short_q;
        slot.emit       = boundary && framed;
    end

    // R6: word length only moves on a measured left-channel start
    p_mode_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(short_q) |-> $past(boundary && framed));
endmodule

// File: rtl/i2srx_deser.sv
`timescale 1ns/1ps
module i2srx_deser
    import i2srx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  slot_t   slot,
    input  logic    din,
    output stereo_t pair,
    output logic    valid
);
    sample_t lbuf, rbuf;
    sample_t l_upd, r_upd;
    logic    chan;

    always_comb begin
        chan  = slot.changed ? slot.lr_prev : slot.lr_now;
        l_upd = lbuf;
        r_upd = rbuf;
        if (!chan) l_upd = put_bit(lbuf, slot.idx, din, slot.short_mode);
        else       r_upd = put_bit(rbuf, slot.idx, din, slot.short_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lbuf  <= '0;
            rbuf  <= '0;
            pair  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= slot.rise && slot.emit;
            if (slot.rise) begin
                lbuf <= (slot.changed && !slot.lr_now) ? '0 : l_upd;
                rbuf <= (slot.changed &&  slot.lr_now) ? '0 : r_upd;
                if (slot.emit)
                    pair <= '{left: l_upd, right: r_upd};
            end
        end
    end

    // R7: strobe lasts a single cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R5: a frame captured in 16-bit mode has empty low bits
    p_short_lsb_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(slot.short_mode)) |->
        (pair.left[SAMPLE_W-SHORT_W-1:0] == '0 && pair.right[SAMPLE_W-SHORT_W-1:0] == '0));
endmodule

// File: rtl/i2srx_route_regs.sv
`timescale 1ns/1ps
module i2srx_route_regs
    import i2srx_pkg::*;
#(
    parameter int N_PIN  = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  stereo_t           pin_pair  [N_PIN],
    input  logic [N_PIN-1:0]  pin_valid,
    output stereo_t           dac_pair  [N_PIN],
    output logic [N_PIN-1:0]  dac_valid
);
    localparam int SELS_W = N_PIN * SEL_W;

    function automatic logic [SELS_W-1:0] default_sel();
        logic [SELS_W-1:0] r;
        r = '0;
        for (int k = 0; k < N_PIN; k++)
            r[k*SEL_W +: SEL_W] = SEL_W'(k);
        return r;
    endfunction

    localparam logic [SELS_W-1:0] DEF_SEL = default_sel();

    logic [SELS_W-1:0] sel_q;
    logic              hit;

    assign hit       = (reg_addr == '0);
    assign reg_rdata = hit ? DATA_W'(sel_q) : '0;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= DEF_SEL;
        else if (reg_we && hit)
            sel_q <= reg_wdata[SELS_W-1:0];
    end

    for (genvar k = 0; k < N_PIN; k++) begin : g_dac
        logic [SEL_W-1:0] s;
        assign s            = sel_q[k*SEL_W +: SEL_W];
        assign dac_pair[k]  = (int'(s) < N_PIN) ? pin_pair[s] : '0;
        assign dac_valid[k] = (int'(s) < N_PIN) ? pin_valid[s] : pin_valid[0];
    end

    // R1: sources come out of reset on their defaults
    p_sel_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q == DEF_SEL));

    // R2: writes elsewhere leave the sources alone
    p_other_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != '0) |=> $stable(sel_q));
endmodule

// File: rtl/i2srx_router.sv
`timescale 1ns/1ps
module i2srx_router
    import i2srx_pkg::*;
#(
    parameter int N_PIN  = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bclk,
    input  logic                      lrclk,
    input  logic [N_PIN-1:0]          din,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic [N_PIN*SAMPLE_W-1:0] dac_left,
    output logic [N_PIN*SAMPLE_W-1:0] dac_right,
    output logic [N_PIN-1:0]          dac_valid
);
    slot_t              slot;
    stereo_t            pin_pair [N_PIN];
    stereo_t            dac_pair [N_PIN];
    logic [N_PIN-1:0]   pin_valid;

    i2srx_frame_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .bclk  (bclk),
        .lrclk (lrclk),
        .slot  (slot)
    );

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
        i2srx_deser u_deser (
            .clk   (clk),
            .rst   (rst),
            .slot  (slot),
            .din   (din[p]),
            .pair  (pin_pair[p]),
            .valid (pin_valid[p])
        );
    end

    i2srx_route_regs #(
        .N_PIN  (N_PIN),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_route (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_pair  (pin_pair),
        .pin_valid (pin_valid),
        .dac_pair  (dac_pair),
        .dac_valid (dac_valid)
    );

    for (genvar k = 0; k < N_PIN; k++) begin : g_out
        assign dac_left [k*SAMPLE_W +: SAMPLE_W] = dac_pair[k].left;
        assign dac_right[k*SAMPLE_W +: SAMPLE_W] = dac_pair[k].right;
    end
endmodule

// File: tb/test_i2srx_router.sv
`timescale 1ns/1ps
module test_i2srx_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        bclk, lrclk;
    logic [2:0]  din;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [71:0] dac_left, dac_right;
    logic [2:0]  dac_valid;

    always #2.5 clk = ~clk;

    i2srx_router i_i2srx_router (
        .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .din(din),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dac_left(dac_left), .dac_right(dac_right),
        .dac_valid(dac_valid)
    );

    int checks = 0, failures = 0;
    logic [23:0] exp_l [3][64];
    logic [23:0] exp_r [3][64];
    string       exp_tag [64];
    int          nexp;
    logic [23:0] cap_l [3][64];
    logic [23:0] cap_r [3][64];
    int          cap_n;
    bit          carry [3];
    bit          model_short;
    logic [5:0]  sel_model;
    bit          prev_v;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: capture strobed pairs, away from the clock edge
    always @(negedge clk) begin
        if (rst) prev_v = 1'b0;
        else begin
            if (dac_valid !== {3{dac_valid[0]}}) begin
                checks++; failures++;
                $display("FAIL R7 strobes differ actual=%b expected=%b", dac_valid, {3{dac_valid[0]}});
            end
            if (dac_valid[0]) begin
                if (prev_v) begin
                    checks++; failures++;
                    $display("FAIL R7 strobe longer than one cycle actual=1 expected=0");
                end
                if (cap_n < 64)
                    for (int k = 0; k < 3; k++) begin
                        cap_l[k][cap_n] = dac_left [k*24 +: 24];
                        cap_r[k][cap_n] = dac_right[k*24 +: 24];
                    end
                cap_n++;
            end
            prev_v = dac_valid[0];
        end
    end

    function automatic bit bitat(logic [23:0] w, int wd, int i);
        return (i < wd) ? w[wd-1-i] : 1'b0;
    endfunction

    function automatic logic [23:0] expect_word(logic [23:0] w, int wd, int lim);
        logic [23:0] r;
        for (int i = 0; i < 24; i++)
            r[23-i] = (i < lim) ? bitat(w, wd, i) : 1'b0;
        return r;
    endfunction

    task automatic slot(bit lr, logic [2:0] d);
        @(negedge clk); bclk = 1'b0; lrclk = lr; din = d;
        @(negedge clk);
        @(negedge clk); bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_half(bit lr, int half, logic [23:0] w [3], int wd);
        logic [2:0] d;
        for (int p = 0; p < 3; p++) d[p] = carry[p];
        slot(lr, d);
        for (int j = 1; j < half; j++) begin
            for (int p = 0; p < 3; p++) d[p] = bitat(w[p], wd, j-1);
            slot(lr, d);
        end
        for (int p = 0; p < 3; p++) carry[p] = bitat(w[p], wd, half-1);
    endtask

    task automatic send_frame(int half, int wd, bit rec, string tag);
        logic [23:0] wl [3];
        logic [23:0] wr [3];
        int lim;
        for (int p = 0; p < 3; p++) begin
            wl[p] = 24'($urandom & ((32'd1 << wd) - 1));
            wr[p] = 24'($urandom & ((32'd1 << wd) - 1));
        end
        send_half(1'b0, half, wl, wd);
        send_half(1'b1, half, wr, wd);
        if (rec && nexp < 64) begin
            lim = model_short ? 16 : 24;
            for (int p = 0; p < 3; p++) begin
                exp_l[p][nexp] = expect_word(wl[p], wd, lim);
                exp_r[p][nexp] = expect_word(wr[p], wd, lim);
            end
            exp_tag[nexp] = tag;
            nexp++;
            model_short = (2*half == 32);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bclk = 1'b0; lrclk = 1'b0; din = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] v);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk); reg_addr = a;
        #1 chk(tag, 32'(reg_rdata), 32'(exp), "register read");
    endtask

    task automatic start_scen(logic [5:0] sel);
        do_reset();
        nexp = 0; cap_n = 0; model_short = 1'b0;
        for (int p = 0; p < 3; p++) carry[p] = 1'b0;
        sel_model = 6'h24;
        if (sel != 6'h24) begin
            reg_write(2'd0, {2'b00, sel});
            sel_model = sel;
        end
        send_frame(24, 24, 1'b0, "");   // primer, never strobed (R7)
        chk("R7", 32'(cap_n), 0, "strobes before first full frame");
    endtask

    task automatic finish_scen(string dtag);
        logic [1:0]  s;
        logic [23:0] el, er;
        string       t;
        send_frame(24, 24, 1'b0, "");   // its first edge closes the last frame
        repeat (4) @(negedge clk);
        chk("R7", 32'(cap_n), 32'(nexp), "strobe count");
        for (int i = 0; i < nexp; i++)
            for (int k = 0; k < 3; k++) begin
                s  = sel_model[k*2 +: 2];
                el = (s == 2'd3) ? 24'd0 : exp_l[s][i];
                er = (s == 2'd3) ? 24'd0 : exp_r[s][i];
                t  = (s == 2'd3) ? "R9" : ((dtag == "") ? exp_tag[i] : dtag);
                chk(t, 32'(cap_l[k][i]), 32'(el), "left sample");
                chk(t, 32'(cap_r[k][i]), 32'(er), "right sample");
            end
    endtask

    initial begin
        void'($urandom(32'd1357));
        do_reset();
        // R1 / R2: register behaviour
        reg_read(2'd0, 8'h24, "R1");
        reg_read(2'd1, 8'h00, "R2");
        reg_write(2'd1, 8'h3F);
        reg_read(2'd0, 8'h24, "R2");
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, 8'h3F, "R2");
        reg_write(2'd0, 8'h12);
        reg_read(2'd0, 8'h12, "R2");

        // R3 / R4 / R10: default routing, random widths and phase lengths
        start_scen(6'h24);
        send_frame(24, 24, 1'b1, "R3");
        for (int f = 0; f < 6; f++)
            send_frame(24 + int'($urandom_range(10)), 16 + int'($urandom_range(8)), 1'b1,
                       (f < 3) ? "R4" : "R10");
        finish_scen("");

        // R8: crossed routing
        start_scen(6'b01_00_10);
        for (int f = 0; f < 4; f++) send_frame(24, 24, 1'b1, "R8");
        finish_scen("");

        // R9: DAC 2 blanked
        start_scen(6'b10_11_00);
        for (int f = 0; f < 3; f++) send_frame(24 + int'($urandom_range(4)), 20, 1'b1, "R8");
        finish_scen("");

        // R5 / R6 / R10: 32-clock frames and the switch back
        start_scen(6'h24);
        send_frame(32, 24, 1'b1, "R10");
        send_frame(16, 16, 1'b1, "R10");
        send_frame(16, 16, 1'b1, "R5");
        send_frame(16, 16, 1'b1, "R5");
        send_frame(32, 24, 1'b1, "R6");
        send_frame(32, 24, 1'b1, "R6");
        send_frame(24, 24, 1'b1, "R10");
        finish_scen("");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule